// File: doc/BRIEF.md
# Per-flow traffic counter table

This block holds a byte counter and a packet counter for every entry of a flow table. A forwarding engine announces each forwarded packet by giving its flow index, its frame length and the entry's count-enable flag, which is bit 15 of that entry's second info word. When counting is enabled globally and the flag is set, the entry gains one packet and the frame's length in bytes. A separate flush input zeroes both counters of one entry, for use when a flow is torn down.

Software reaches the counters through a small word-addressed register file. It writes an entry index together with a start flag to the command register. It then polls until the block drops that flag, and reads the 48-bit byte count and the 40-bit packet count from three result words. When the read-clear option is set, every completed read also zeroes the entry, so that each read returns the traffic added since the previous read. A packet that reaches the entry in the very cycle its read completes is kept. The read returns the value from before that packet, and the entry is left holding only that packet.

Register map (word address on `wr_addr`/`rd_addr`): 0 = configuration (bit 0 counting enable, bit 1 read-clear); 1 = command (bits 13:0 entry index, bit 16 start/busy); 2, 3, 4 = result words 0, 1, 2.

Top module: `flow_acct_top`

## Requirements
- R1: After reset, all five registers read as zero and every entry's counters are zero.
- R2: A packet with `pkt_valid` high, configuration bit 0 set and `pkt_cnt_en` high adds 1 to the entry's packet counter and `pkt_len` to its byte counter.
- R3: A packet is not counted when configuration bit 0 is clear or when `pkt_cnt_en` is low. The entry's counters then keep their values.
- R4: A command write with bit 16 set while idle makes bit 16 of the command register read 1 from the next cycle. It reads 0 again exactly two cycles after the write edge, and from then on the result words hold the entry's counts.
- R5: Result word 0 holds byte count bits 31:0. Word 1 holds byte bits 47:32 in bits 15:0 and packet bits 15:0 in bits 31:16. Word 2 holds packet bits 39:16 in bits 23:0 and zero in bits 31:24.
- R6: With configuration bit 1 clear, a read leaves the entry unchanged. With it set, a completed read zeroes the entry.
- R7: If a counted packet hits an entry in the cycle its read-clear read completes, the read returns the prior counts and the entry then holds exactly that one packet and its length.
- R8: `flush_valid` zeroes both counters of `flush_idx` at the next edge. This takes priority over a packet to the same entry in the same cycle.
- R9: A write to the command register while busy is ignored, so the index and the read in progress are unaffected.
- R10: The result words keep their values until the next read completes, even while the entry keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | A forwarded packet is reported this cycle |
| pkt_idx | input | IDX_W | Flow entry of the packet |
| pkt_len | input | LEN_W | Frame length in bytes |
| pkt_cnt_en | input | 1 | Entry's count-enable flag (bit 15 of its second info word) |
| flush_valid | input | 1 | Zero the counters of one entry |
| flush_idx | input | IDX_W | Entry to zero |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |

## Verification
On every cycle, the assertions check that a counted packet adds exactly one packet and its length and that a skipped packet leaves the entry untouched. They also check that a flush leaves the entry at zero, that busy lasts exactly the read latency, and that the command index and the result words do not move outside a completed read. The bench scenarios are needed for the register packing with counts past 32 and 16 bits, for read-clear turning reads into deltas, and for the same-cycle collision of a packet with a read-clear. They also cover the flush-versus-packet priority and the reset contents seen through software reads.

// File: rtl/flow_acct_pkg.sv
package flow_acct_pkg;

    localparam int BYTE_W         = 48;
    localparam int PKT_W          = 40;
    localparam int CMD_IDX_W      = 14;
    localparam int START_BIT      = 16;
    localparam int RES_W          = 96;

    typedef struct packed {
        logic [BYTE_W-1:0] bytes;
        logic [PKT_W-1:0]  pkts;
    } flow_cnt_t;

    typedef enum logic [2:0] {
        A_CFG  = 3'd0,
        A_CMD  = 3'd1,
        A_RES0 = 3'd2,
        A_RES1 = 3'd3,
        A_RES2 = 3'd4
    } reg_addr_e;

    // One more packet of the given length; both fields wrap.
    function automatic flow_cnt_t bump(flow_cnt_t c, logic [BYTE_W-1:0] len);
        flow_cnt_t r;
        r.bytes = c.bytes + len;
        r.pkts  = c.pkts + PKT_W'(1);
        return r;
    endfunction

    // Spread a counter pair across three 32-bit result words.
    function automatic logic [RES_W-1:0] pack_result(flow_cnt_t c);
        return {8'h00, c.pkts[39:16], c.pkts[15:0], c.bytes[47:32], c.bytes[31:0]};
    endfunction

endpackage

// File: rtl/flow_acct_table.sv
module flow_acct_table
    import flow_acct_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_valid,
    input  logic [IDX_W-1:0] inc_idx,
    input  logic [LEN_W-1:0] inc_len,
    input  logic             rc_fire,
    input  logic [IDX_W-1:0] rc_idx,
    input  logic             flush_valid,
    input  logic [IDX_W-1:0] flush_idx,
    output flow_cnt_t        entries [1<<IDX_W]
);
    localparam int DEPTH = 1 << IDX_W;

    flow_cnt_t cnt_q [DEPTH];
    flow_cnt_t cnt_d [DEPTH];

    // Order of precedence: read-clear zeroes first, the packet lands on top,
    // a flush overrides both.
    always_comb begin
        for (int e = 0; e < DEPTH; e++) begin
            cnt_d[e] = cnt_q[e];
            if (rc_fire && rc_idx == IDX_W'(e))
                cnt_d[e] = '0;
            if (inc_valid && inc_idx == IDX_W'(e))
                cnt_d[e] = bump(cnt_d[e], BYTE_W'(inc_len));
            if (flush_valid && flush_idx == IDX_W'(e))
                cnt_d[e] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < DEPTH; e++)
                cnt_q[e] <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign entries = cnt_q;

endmodule

// File: rtl/flow_acct_regs.sv
module flow_acct_regs
    import flow_acct_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int READ_LAT = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [31:0]          wr_data,
    input  logic [2:0]           rd_addr,
    output logic [31:0]          rd_data,
    input  flow_cnt_t            rd_cnt,
    output logic                 cfg_en,
    output logic                 cfg_rdclr,
    output logic [IDX_W-1:0]     rd_idx,
    output logic                 rc_fire,
    output logic                 busy,
    output logic [CMD_IDX_W-1:0] cmd_idx,
    output logic [RES_W-1:0]     res
);
    localparam int LAT_W = (READ_LAT > 1) ? $clog2(READ_LAT) : 1;

    logic                 en_q, rdclr_q, busy_q;
    logic [LAT_W-1:0]     lat_q;
    logic [CMD_IDX_W-1:0] idx_q;
    logic [RES_W-1:0]     res_q;

    logic cfg_wr, cmd_wr, start, done;
    logic unused_wr;

    assign cfg_wr = wr_en && (wr_addr == 3'(A_CFG));
    assign cmd_wr = wr_en && (wr_addr == 3'(A_CMD)) && !busy_q;
    assign start  = cmd_wr && wr_data[START_BIT];
    assign done   = busy_q && (lat_q == LAT_W'(READ_LAT - 1));
    assign unused_wr = ^{wr_data[31:START_BIT+1], wr_data[START_BIT-1:CMD_IDX_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            rdclr_q <= 1'b0;
            busy_q  <= 1'b0;
            lat_q   <= '0;
            idx_q   <= '0;
            res_q   <= '0;
        end else begin
            if (cfg_wr) begin
                en_q    <= wr_data[0];
                rdclr_q <= wr_data[1];
            end
            if (cmd_wr)
                idx_q <= wr_data[CMD_IDX_W-1:0];
            if (start) begin
                busy_q <= 1'b1;
                lat_q  <= '0;
            end else if (done) begin
                busy_q <= 1'b0;
                res_q  <= pack_result(rd_cnt);
            end else if (busy_q) begin
                lat_q <= lat_q + LAT_W'(1);
            end
        end
    end

    always_comb begin
        case (rd_addr)
            3'(A_CFG):  rd_data = {30'd0, rdclr_q, en_q};
            3'(A_CMD):  rd_data = {15'd0, busy_q, 2'd0, idx_q};
            3'(A_RES0): rd_data = res_q[31:0];
            3'(A_RES1): rd_data = res_q[63:32];
            3'(A_RES2): rd_data = res_q[95:64];
            default:    rd_data = 32'd0;
        endcase
    end

    assign cfg_en    = en_q;
    assign cfg_rdclr = rdclr_q;
    assign rd_idx    = idx_q[IDX_W-1:0];
    assign rc_fire   = done && rdclr_q;
    assign busy      = busy_q;
    assign cmd_idx   = idx_q;
    assign res       = res_q;

endmodule

// File: rtl/flow_acct_top.sv
module flow_acct_top
    import flow_acct_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int LEN_W    = 16,
    parameter int READ_LAT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pkt_valid,
    input  logic [IDX_W-1:0] pkt_idx,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             pkt_cnt_en,
    input  logic             flush_valid,
    input  logic [IDX_W-1:0] flush_idx,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [2:0]       rd_addr,
    output logic [31:0]      rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic                 cfg_en, cfg_rdclr, busy, rc_fire, inc_valid;
    logic [IDX_W-1:0]     rd_idx;
    logic [CMD_IDX_W-1:0] cmd_idx;
    logic [RES_W-1:0]     res;
    flow_cnt_t            rd_cnt;
    flow_cnt_t            entries [DEPTH];

    assign inc_valid = pkt_valid && cfg_en && pkt_cnt_en;
    assign rd_cnt    = entries[rd_idx];

    flow_acct_regs #(.IDX_W(IDX_W), .READ_LAT(READ_LAT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rd_cnt    (rd_cnt),
        .cfg_en    (cfg_en),
        .cfg_rdclr (cfg_rdclr),
        .rd_idx    (rd_idx),
        .rc_fire   (rc_fire),
        .busy      (busy),
        .cmd_idx   (cmd_idx),
        .res       (res)
    );

    flow_acct_table #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_tab (
        .clk         (clk),
        .rst         (rst),
        .inc_valid   (inc_valid),
        .inc_idx     (pkt_idx),
        .inc_len     (pkt_len),
        .rc_fire     (rc_fire),
        .rc_idx      (rd_idx),
        .flush_valid (flush_valid),
        .flush_idx   (flush_idx),
        .entries     (entries)
    );

endmodule

// File: rtl/flow_acct_chk.sv
module flow_acct_chk
    import flow_acct_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int LEN_W    = 16,
    parameter int READ_LAT = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 pkt_valid,
    input logic [IDX_W-1:0]     pkt_idx,
    input logic [LEN_W-1:0]     pkt_len,
    input logic                 pkt_cnt_en,
    input logic                 flush_valid,
    input logic [IDX_W-1:0]     flush_idx,
    input logic                 cfg_en,
    input logic                 busy,
    input logic [CMD_IDX_W-1:0] cmd_idx,
    input logic [RES_W-1:0]     res,
    input flow_cnt_t            entries [1<<IDX_W]
);
    logic [7:0]       bcnt;
    logic             cnt_ok, skip_ok, fl_q;
    logic [IDX_W-1:0] pidx, fidx;
    logic [LEN_W-1:0] plen;
    flow_cnt_t        prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt    <= '0;
            cnt_ok  <= 1'b0;
            skip_ok <= 1'b0;
            fl_q    <= 1'b0;
            pidx    <= '0;
            fidx    <= '0;
            plen    <= '0;
            prev    <= '0;
        end else begin
            bcnt    <= busy ? bcnt + 8'd1 : 8'd0;
            cnt_ok  <= pkt_valid && cfg_en && pkt_cnt_en && !flush_valid && !busy;
            skip_ok <= pkt_valid && !(cfg_en && pkt_cnt_en) && !flush_valid && !busy;
            fl_q    <= flush_valid;
            pidx    <= pkt_idx;
            fidx    <= flush_idx;
            plen    <= pkt_len;
            prev    <= entries[pkt_idx];
        end
    end

    p_count_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_ok |-> (entries[pidx].pkts == prev.pkts + PKT_W'(1)) &&
                   (entries[pidx].bytes == prev.bytes + BYTE_W'(plen)));

    p_skip_r3: assert property (@(posedge clk) disable iff (rst)
        skip_ok |-> entries[pidx] == prev);

    p_busy_len_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> bcnt < 8'(READ_LAT));

    p_done_len_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(bcnt) == 8'(READ_LAT - 1));

    p_flush_r8: assert property (@(posedge clk) disable iff (rst)
        fl_q |-> entries[fidx] == '0);

    p_cmd_hold_r9: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> $stable(cmd_idx));

    p_res_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy) |-> $stable(res));

endmodule

bind flow_acct_top flow_acct_chk #(.IDX_W(IDX_W), .LEN_W(LEN_W), .READ_LAT(READ_LAT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pkt_valid   (pkt_valid),
    .pkt_idx     (pkt_idx),
    .pkt_len     (pkt_len),
    .pkt_cnt_en  (pkt_cnt_en),
    .flush_valid (flush_valid),
    .flush_idx   (flush_idx),
    .cfg_en      (cfg_en),
    .busy        (busy),
    .cmd_idx     (cmd_idx),
    .res         (res),
    .entries     (entries)
);

// File: tb/flow_acct_top_test.sv
module flow_acct_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_valid = 1'b0;
    logic [7:0]  pkt_idx = '0;
    logic [15:0] pkt_len = '0;
    logic        pkt_cnt_en = 1'b0;
    logic        flush_valid = 1'b0;
    logic [7:0]  flush_idx = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [47:0] mb [256];
    logic [39:0] mp [256];
    bit m_en = 0, m_rc = 0;

    flow_acct_top uut (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_idx(pkt_idx),
        .pkt_len(pkt_len), .pkt_cnt_en(pkt_cnt_en), .flush_valid(flush_valid),
        .flush_idx(flush_idx), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    task automatic check(string tag, logic [95:0] act, logic [95:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [95:0] expect_words(logic [47:0] b, logic [39:0] p);
        logic [31:0] w0, w1, w2;
        w0 = b[31:0];
        w1 = {p[15:0], b[47:32]};
        w2 = {8'h00, p[39:16]};
        return {w2, w1, w0};
    endfunction

    task automatic rreg(logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wcfg(bit en, bit rc);
        wr_en = 1; wr_addr = 3'd0; wr_data = {30'd0, rc, en};
        @(negedge clk);
        wr_en = 0;
        m_en = en; m_rc = rc;
    endtask

    task automatic model_pkt(int idx, logic [15:0] len, bit fl);
        if (m_en && fl) begin
            mb[idx] = mb[idx] + 48'(len);
            mp[idx] = mp[idx] + 40'd1;
        end
    endtask

    task automatic send(int idx, logic [15:0] len, bit fl);
        pkt_valid = 1; pkt_idx = 8'(idx); pkt_len = len; pkt_cnt_en = fl;
        @(negedge clk);
        pkt_valid = 0;
        model_pkt(idx, len, fl);
    endtask

    task automatic read_res(output logic [95:0] r);
        logic [31:0] w0, w1, w2;
        rreg(3'd2, w0); rreg(3'd3, w1); rreg(3'd4, w2);
        r = {w2, w1, w0};
    endtask

    // Full read; optional packet landing on the completion edge, optional
    // command write while busy.
    task automatic do_read(string tag, int idx, bit coinc, logic [15:0] clen, bit poke);
        logic [31:0] d;
        logic [95:0] r, e;
        wr_en = 1; wr_addr = 3'd1; wr_data = 32'h0001_0000 | 32'(idx);
        @(negedge clk);
        wr_en = 0;
        rreg(3'd1, d);
        check({tag, " R4 busy after start"}, 96'(d[16]), 96'd1);
        if (poke) begin
            wr_en = 1; wr_addr = 3'd1; wr_data = 32'h0001_0000 | 32'(idx ^ 1);
        end
        @(negedge clk);
        wr_en = 0;
        rreg(3'd1, d);
        check({tag, " R4 still busy"}, 96'(d[16]), 96'd1);
        if (poke)
            check({tag, " R9 index kept while busy"}, 96'(d[13:0]), 96'(idx));
        if (coinc) begin
            pkt_valid = 1; pkt_idx = 8'(idx); pkt_len = clen; pkt_cnt_en = 1;
        end
        @(negedge clk);
        pkt_valid = 0;
        rreg(3'd1, d);
        check({tag, " R4 idle after latency"}, 96'(d[16]), 96'd0);
        read_res(r);
        e = expect_words(mb[idx], mp[idx]);
        check({tag, " R5 result words"}, r, e);
        if (m_rc) begin
            mb[idx] = '0; mp[idx] = '0;
        end
        if (coinc) model_pkt(idx, clen, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [95:0] r, r2;
        int unsigned seed;
        for (int i = 0; i < 256; i++) begin mb[i] = '0; mp[i] = '0; end
        seed = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset contents
        for (int a = 0; a < 5; a++) begin
            rreg(3'(a), d);
            check("R1 register zero after reset", 96'(d), 96'd0);
        end
        do_read("R1 entry zero", 7, 0, 16'd0, 0);

        // R3: disabled globally, then flag low
        send(3, 16'd100, 1);
        wcfg(1, 0);
        send(3, 16'd200, 0);
        do_read("R3 not counted", 3, 0, 16'd0, 0);

        // R2: simple counts
        send(3, 16'd64, 1);
        send(3, 16'd1500, 1);
        send(5, 16'd9, 1);
        do_read("R2 counted idx3", 3, 0, 16'd0, 0);
        do_read("R2 counted idx5", 5, 0, 16'd0, 0);

        // R6: no read-clear, read is non-destructive
        do_read("R6 repeat read", 3, 0, 16'd0, 0);

        // R10: results hold while the entry keeps counting
        read_res(r);
        send(3, 16'd33, 1);
        send(3, 16'd44, 1);
        read_res(r2);
        check("R10 results held", r2, r);

        // R9: command write while busy is ignored
        do_read("R9 poke", 5, 0, 16'd0, 1);

        // R5: large counts crossing word boundaries
        pkt_valid = 1; pkt_idx = 8'd9; pkt_len = 16'hFFFF; pkt_cnt_en = 1;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            model_pkt(9, 16'hFFFF, 1);
        end
        pkt_valid = 0;
        do_read("R5 wide counts", 9, 0, 16'd0, 0);

        // R6: read-clear makes reads deltas
        wcfg(1, 1);
        do_read("R6 clear read", 9, 0, 16'd0, 0);
        do_read("R6 after clear", 9, 0, 16'd0, 0);
        send(9, 16'd10, 1);
        do_read("R6 delta", 9, 0, 16'd0, 0);

        // R7: packet in the cycle the read-clear read completes
        send(4, 16'd300, 1);
        send(4, 16'd5, 1);
        do_read("R7 collision", 4, 1, 16'd77, 0);
        do_read("R7 keeps increment", 4, 0, 16'd0, 0);

        // R8: flush, and flush against a packet in the same cycle
        wcfg(1, 0);
        send(6, 16'd50, 1);
        flush_valid = 1; flush_idx = 8'd6;
        @(negedge clk);
        flush_valid = 0;
        mb[6] = '0; mp[6] = '0;
        do_read("R8 flush", 6, 0, 16'd0, 0);
        send(6, 16'd50, 1);
        flush_valid = 1; flush_idx = 8'd6;
        pkt_valid = 1; pkt_idx = 8'd6; pkt_len = 16'd70; pkt_cnt_en = 1;
        @(negedge clk);
        flush_valid = 0; pkt_valid = 0;
        mb[6] = '0; mp[6] = '0;
        do_read("R8 flush wins", 6, 0, 16'd0, 0);

        // Random mix of R2, R3, R8, then R6 readback
        for (int round = 0; round < 3; round++) begin
            wcfg(1'($urandom % 4 != 0), 1'(round == 1));
            for (int i = 0; i < 300; i++) begin
                int idx, fi;
                logic [15:0] len;
                bit fl, fv;
                idx = 16 + int'($urandom % 16);
                len = 16'($urandom % 1600);
                fl  = ($urandom % 4) != 0;
                fv  = ($urandom % 32) == 0;
                fi  = 16 + int'($urandom % 16);
                pkt_valid = 1; pkt_idx = 8'(idx); pkt_len = len; pkt_cnt_en = fl;
                flush_valid = fv; flush_idx = 8'(fi);
                @(negedge clk);
                pkt_valid = 0; flush_valid = 0;
                model_pkt(idx, len, fl);
                if (fv) begin mb[fi] = '0; mp[fi] = '0; end
            end
            wcfg(1, 1'($urandom % 2));
            for (int k = 16; k < 32; k++)
                do_read("R2 R3 R8 random", k, 0, 16'd0, 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule